// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block times the column side of a single synchronous DRAM read or write burst. A controller pulses a start command with the transfer direction, an 8-bit starting column and a mode word. The mode word sets the burst length, the beat ordering and the CAS latency. In each beat cycle the block then presents one column address and a beat-valid flag. For a write it gives per-byte write strobes in that same cycle. For a read it gives a read-data-valid flag and per-byte output enables aligned to the programmed latency.

Each byte lane has a mask input. High masks the lane and low lets it through. On a write the mask acts in the cycle it is driven. On a read it acts on the data that appears two edges after the mask is sampled. A stop input ends the burst after the current beat. A new start always begins a fresh burst at once, even if one is still running.

Mode word fields: bits [2:0] give the length code, bit 3 selects interleaved ordering, and bits [6:4] hold the latency code.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, and while no burst has been started, col_vld_o, rd_vld_o, wr_stb_o and rd_oe_o are all zero.
- R2: In the cycle after start_i is sampled, col_vld_o is high and col_o equals the starting column. An unstopped burst holds col_vld_o high for exactly its length in consecutive cycles.
- R3: With sequential ordering (mode bit 3 low), beat b has column (start & ~M) | ((start + b) & M), where M is the length minus one. The column wraps inside the aligned block.
- R4: With interleaved ordering (mode bit 3 high), beat b has column (start & ~M) | ((start ^ b) & M).
- R5: Length code 3'b111 is a full-page burst. Beat b has column (start + b) mod 256, and the burst runs until stopped. Mode bit 3 is ignored for full page.
- R6: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give 1, 2, 4 and 8 beats. Any other code except 3'b111 gives 1 beat.
- R7: If stop_i is high in a beat cycle, that beat is the last one. col_vld_o is low in the next cycle unless start_i is also high.
- R8: During a write beat, wr_stb_o equals the inverse of dqm_i in the same cycle. Otherwise it is zero.
- R9: Latency code 3 (mode bits [6:4] = 3'd3) gives a latency of 3. Any other code gives 2. rd_vld_o is high exactly in the cycles that follow a read beat cycle by that latency.
- R10: While rd_vld_o is high, rd_oe_o equals the inverse of dqm_i as sampled two rising edges before the edge that opened the current cycle. Otherwise rd_oe_o is zero.
- R11: A start during a running burst takes priority over stop_i and over the burst's end. The next cycle shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a burst |
| write_i | input | 1 | Direction at start: 1 write, 0 read |
| col_i | input | 8 | Starting column at start |
| mode_i | input | 7 | Mode word: [2:0] length, [3] interleave, [6:4] latency |
| stop_i | input | 1 | End the burst after the current beat |
| dqm_i | input | NB | Per-byte mask, high masks |
| col_o | output | 8 | Column of the current beat |
| col_vld_o | output | 1 | A beat is issued this cycle |
| wr_stb_o | output | NB | Per-byte write strobes |
| rd_vld_o | output | 1 | Read data valid |
| rd_oe_o | output | NB | Per-byte read output enables |

## Verification
A beat counter that is wrong by one shows up in col_o on the very next beat, or as a burst that is one cycle too long or too short. A wrong ordering flag or block mask gives a wrong column at the first wrap point. For a length-8 burst starting mid-block, that is within eight cycles. A wrongly latched latency or direction shifts or drops rd_vld_o two to three cycles after the beat that caused it. A mask history that is one stage too short or too long gives lane enables from the wrong beat on the first read where dqm_i changes between beats.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int COL_W = 8;
  localparam int LEN_LSB = 0;
  localparam int ILV_BIT = 3;
  localparam int LAT_LSB = 4;
  localparam int MODE_W = 7;
  localparam logic [2:0] LEN_FULL = 3'b111;

  typedef logic [COL_W-1:0] col_t;

  function automatic col_t len_mask(input logic [2:0] code);
    case (code)
      3'b001:  len_mask = col_t'(1);
      3'b010:  len_mask = col_t'(3);
      3'b011:  len_mask = col_t'(7);
      LEN_FULL: len_mask = '1;
      default: len_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
  import sbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  col_t       col_i,
  input  logic [2:0] code_i,
  input  logic       ilv_i,
  output logic       act_o,
  output col_t       col_o
);
  logic act_q, full_q, ilv_q;
  col_t cnt_q, base_q, mask_q, off;
  logic full_d;

  assign full_d = (code_i == LEN_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      cnt_q  <= '0;
      base_q <= col_i;
      mask_q <= len_mask(code_i);
      full_q <= full_d;
      ilv_q  <= ilv_i & ~full_d;
    end else if (act_q) begin
      if (stop_i || (!full_q && cnt_q == mask_q)) act_q <= 1'b0;
      else                                        cnt_q <= cnt_q + 1'b1;
    end
  end

  // offset bits only; upper bits keep the aligned block
  assign off   = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign col_o = (base_q & ~mask_q) | (off & mask_q);
  assign act_o = act_q;

  // R2
  first_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> act_o && col_o == $past(col_i));
  // R7
  stop_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o && stop_i && !start_i |=> !act_o);
  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && !full_q |-> cnt_q <= mask_q);
endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
  parameter int NB    = 2,
  parameter int MAX_L = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  input  logic          lat3_i,
  input  logic [NB-1:0] dqm_i,
  output logic          rd_vld_o,
  output logic [NB-1:0] rd_oe_o
);
  logic [MAX_L-1:0] pipe_q;
  logic [NB-1:0]    dqm1_q, dqm2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      dqm1_q <= '1;
      dqm2_q <= '1;
    end else begin
      pipe_q <= {pipe_q[MAX_L-2:0], beat_i};
      dqm1_q <= dqm_i;
      dqm2_q <= dqm1_q;
    end
  end

  assign rd_vld_o = lat3_i ? pipe_q[2] : pipe_q[1];
  assign rd_oe_o  = rd_vld_o ? ~dqm2_q : '0;

  // R9
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(beat_i, 2) || $past(beat_i, 3));
  // R10
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |rd_oe_o |-> rd_vld_o);
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              stop_i,
  input  logic [NB-1:0]     dqm_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_vld_o,
  output logic [NB-1:0]     wr_stb_o,
  output logic              rd_vld_o,
  output logic [NB-1:0]     rd_oe_o
);
  localparam int MAX_L = 3;

  logic wr_q, lat3_q, act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      lat3_q <= 1'b0;
    end else if (start_i) begin
      wr_q   <= write_i;
      lat3_q <= (mode_i[LAT_LSB +: 3] == 3'd3);
    end
  end

  sbs_col_gen i_col_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .col_i   (col_i),
    .code_i  (mode_i[LEN_LSB +: 3]),
    .ilv_i   (mode_i[ILV_BIT]),
    .act_o   (act),
    .col_o   (col_o)
  );

  sbs_rd_pipe #(.NB(NB), .MAX_L(MAX_L)) i_rd_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .beat_i   (act & ~wr_q),
    .lat3_i   (lat3_q),
    .dqm_i    (dqm_i),
    .rd_vld_o (rd_vld_o),
    .rd_oe_o  (rd_oe_o)
  );

  assign col_vld_o = act;
  assign wr_stb_o  = (act && wr_q) ? ~dqm_i : '0;

  // R8
  stb_in_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |wr_stb_o |-> col_vld_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_vld_o |-> wr_stb_o == '0);
endmodule

// File: tb/test_sdram_burst_seq.sv
`timescale 1ns/1ps
module test_sdram_burst_seq;
  localparam int NB = 2;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       start_i = 0, write_i = 0, stop_i = 0;
  logic [7:0] col_i = 0;
  logic [6:0] mode_i = 0;
  logic [1:0] dqm_i = 0;
  logic [7:0] col_o;
  logic       col_vld_o, rd_vld_o;
  logic [1:0] wr_stb_o, rd_oe_o;

  sdram_burst_seq #(.NB(NB)) i_sdram_burst_seq (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, cur_wr = 0;
  int cur_lat = 2;
  string tag = "R2";
  logic [7:0] col_q[$];
  logic rd_exp[32];
  logic [1:0] h1 = 0, h2 = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    h2  <= h1;
    h1  <= dqm_i;
  end

  function automatic logic [6:0] mk(input logic [2:0] code, input bit ilv, input logic [2:0] lat);
    return {lat, ilv, code};
  endfunction

  function automatic int blen(input logic [2:0] code);
    case (code)
      3'b000: return 1; 3'b001: return 2; 3'b010: return 4;
      3'b011: return 8; 3'b111: return 256; default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                         input bit ilv, input int b);
    logic [7:0] m, bb;
    bb = 8'(b);
    if (code == 3'b111) return s + bb;
    m = 8'(blen(code) - 1);
    return ilv ? ((s & ~m) | ((s ^ bb) & m)) : ((s & ~m) | ((s + bb) & m));
  endfunction

  // driver: entered right after a negedge
  task automatic burst(input bit wr, input logic [7:0] col, input logic [6:0] mode,
                       input int stop_at, input int restart_at, input string r);
    int n;
    start_i = 1; write_i = wr; col_i = col; mode_i = mode;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 0; cur_wr = wr; tag = r;
    cur_lat = (mode[6:4] == 3'd3) ? 3 : 2;
    n = blen(mode[2:0]);
    if (stop_at >= 0) n = stop_at + 1;
    if (restart_at >= 0) n = restart_at + 1;
    for (int b = 0; b < n; b++) begin
      dqm_i  = 2'(b * 3 + 1);
      stop_i = (b == stop_at);
      col_q.push_back(exp_col(col, mode[2:0], mode[3], b));
      if (restart_at >= 0 && b == n - 1) return;
      @(posedge clk_i); @(negedge clk_i);
    end
    stop_i = 0; dqm_i = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  // monitor / scoreboard
  initial begin
    foreach (rd_exp[i]) rd_exp[i] = 0;
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i); #1;
      if (col_vld_o) begin
        if (col_q.size() == 0) chk(0, "R2/R6/R7 extra beat", col_o, 0);
        else begin
          logic [7:0] e;
          e = col_q.pop_front();
          chk(col_o == e, tag, col_o, e);
        end
        if (!cur_wr) rd_exp[(cyc + cur_lat) % 32] = 1;
      end
      chk(wr_stb_o == ((col_vld_o && cur_wr) ? ~dqm_i : 2'b00), "R8", wr_stb_o,
          (col_vld_o && cur_wr) ? ~dqm_i : 2'b00);
      chk(rd_vld_o == rd_exp[cyc % 32], "R9", rd_vld_o, rd_exp[cyc % 32]);
      chk(rd_oe_o == (rd_exp[cyc % 32] ? ~h2 : 2'b00), "R10", rd_oe_o,
          rd_exp[cyc % 32] ? ~h2 : 2'b00);
      rd_exp[cyc % 32] = 0;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    chk({col_vld_o, rd_vld_o, wr_stb_o, rd_oe_o} == 0, "R1", {col_vld_o, rd_vld_o, wr_stb_o, rd_oe_o}, 0);
    rst_ni = 1;
    idle(2);
    chk({col_vld_o, rd_vld_o, wr_stb_o, rd_oe_o} == 0, "R1", {col_vld_o, rd_vld_o, wr_stb_o, rd_oe_o}, 0);
    burst(1, 8'h16, mk(3'b010, 0, 3'd2), -1, -1, "R3 seq wr bl4");   idle(5);
    burst(0, 8'h2D, mk(3'b011, 0, 3'd2), -1, -1, "R3 seq rd bl8");   idle(5);
    burst(0, 8'h2D, mk(3'b011, 1, 3'd3), -1, -1, "R4 ilv rd bl8");   idle(5);
    burst(1, 8'h03, mk(3'b010, 1, 3'd3), -1, -1, "R4 ilv wr bl4");   idle(5);
    burst(0, 8'h41, mk(3'b000, 0, 3'd2), -1, -1, "R6 bl1");          idle(5);
    burst(0, 8'h41, mk(3'b001, 0, 3'd3), -1, -1, "R6 bl2");          idle(5);
    burst(0, 8'h77, mk(3'b101, 0, 3'd2), -1, -1, "R6 reserved");     idle(5);
    burst(0, 8'hFC, mk(3'b111, 0, 3'd3), 9, -1, "R5 full rd wrap");  idle(5);
    burst(1, 8'hF0, mk(3'b111, 1, 3'd2), 20, -1, "R5 full ilv ign"); idle(5);
    burst(0, 8'h2A, mk(3'b011, 0, 3'd2), 2, -1, "R7 stop");          idle(5);
    // R11: restart with stop also high
    burst(0, 8'h10, mk(3'b011, 0, 3'd3), 3, 3, "R11 first");
    burst(0, 8'h86, mk(3'b010, 1, 3'd3), -1, -1, "R11 restart");     idle(6);
    chk(col_q.size() == 0, "R2 beats pending", col_q.size(), 0);
    chk({col_vld_o, rd_vld_o, wr_stb_o, rd_oe_o} == 0, "R1 idle", {col_vld_o, rd_vld_o, wr_stb_o, rd_oe_o}, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule